// File: doc/BRIEF.md
# Layer-Parallel Gibbs Sampler for a Tiny Binary RBM

This block runs block Gibbs sampling on a restricted Boltzmann machine with three visible and two hidden binary stochastic units. Integer weights and biases are written through a small register port before a run and stay fixed while the chain runs. No learning logic exists. A run starts by loading the visible layer from an input port and clearing the hidden layer. The block then alternates layer updates. Every hidden unit is sampled at once from the current visible layer, and then every visible unit is sampled at once from the new hidden layer.

Each unit samples by comparing its integer potential against a per-unit noise word. The potential is the bias, plus the weights of the active units in the opposite layer, minus a leak value that is shared by all units. Every layer update is a fixed pass of three clocks: one update clock and two synchronization clocks. Inference mode performs one visible-to-hidden pass with no burn-in. Generative mode runs a programmed number of full sweeps and emits the joint state after each one, so a host can build a histogram of the sampled distribution.

Top module: `rbm_gibbs_sequencer`

## Requirements
- R1: While reset is held and after it is released, `busy` and `sweep_valid` are 0 and both layer states are all zeros.
- R2: The configuration registers are 8-bit two's complement values. The weight between visible unit i and hidden unit j is at address 2*i+j (0..5). Visible bias i is at 6+i, and hidden bias j is at 9+j. A write to address 11..15 changes nothing.
- R3: A configuration write made while `busy` is high is discarded. Every later sample uses the values held before the run.
- R4: `start` while idle loads `vis_state` from `vis_init`, clears `hid_state` and raises `busy` on the same edge. `start` while busy has no effect.
- R5: A unit fires (state 1) exactly when bias + sum of the weights to active units of the other layer - leak >= its noise word, compared as signed values. Noise slice k (bits 8k+7..8k) belongs to visible unit k for k = 0..2 and to hidden unit k-3 for k = 3..4.
- R6: A hidden update uses only the visible state, and a visible update uses only the hidden state just produced. While idle with no `start`, both states hold.
- R7: In inference mode (`gen_mode`=0), `sweep_valid` rises on the third edge after the start edge with the visible layer unchanged. `busy` falls on that same edge.
- R8: In generative mode (`gen_mode`=1), each sweep is a hidden pass followed by a visible pass and takes six clocks. Sweep k (k=1,2,…) reports on edge 6k after the start edge.
- R9: `iter_count` (17 bits) sets the number of sweeps, and 0 is treated as 1. `busy` falls on the edge that emits the final `sweep_valid`.
- R10: `sweep_valid` is a one-clock pulse, and `joint_state` = {vis_state[2:0], hid_state[1:0]}.
- R11: The one `leak` input is subtracted from the potential of every unit. With a zero weight sum, a unit whose bias equals leak + noise fires, and raising leak by one stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write value, signed |
| start | input | 1 | Begin a run when idle |
| gen_mode | input | 1 | 0 = single inference pass, 1 = generative chain |
| iter_count | input | 17 | Sweeps in generative mode (0 means 1) |
| vis_init | input | 3 | Visible state loaded on start |
| leak | input | 8 | Shared signed leak, subtracted from every unit |
| thr_noise | input | 40 | Per-unit signed threshold noise, 8 bits per unit |
| busy | output | 1 | High from the start edge to the final report |
| sweep_valid | output | 1 | One-clock pulse when a result is ready |
| joint_state | output | 5 | {visible, hidden} state |
| vis_state | output | 3 | Current visible layer |
| hid_state | output | 2 | Current hidden layer |

## Verification
Counting from the edge that accepts `start`, the loaded visible state and the cleared hidden state appear after one edge. An inference result and the fall of `busy` are due on the third edge. Generative sweep k is due on edge 6k, and the final one also drops `busy`. The bench drives inputs and samples outputs on the falling edge. It counts those falling edges from the start pulse and checks each result exactly at its due count, and it requires `sweep_valid` to be low at every other count. Noise is changed only in the half-cycle right after a report, so the bench model knows which noise each update edge saw.

// File: rtl/rbm_gibbs_pkg.sv
`timescale 1ns/1ps
// Shared types for the Gibbs sampling sequencer.
// Assumes: consumers import the package; no parameters live here.
package rbm_gibbs_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_UPDATE,
        SEQ_SYNC_A,
        SEQ_SYNC_B
    } seq_state_t;

    typedef enum logic {
        LAYER_HID,
        LAYER_VIS
    } layer_sel_t;
endpackage

// File: rtl/rbm_param_regs.sv
`timescale 1ns/1ps
// Weight and bias register file for the sampler.
// Holds NV*NH weights, then NV visible biases, then NH hidden biases, at
// consecutive addresses. Assumes writes are blocked by 'lock' during a run;
// addresses past the last register are dropped.
module rbm_param_regs #(
    parameter int NV     = 3,
    parameter int NH     = 2,
    parameter int WW     = 8,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WW-1:0]        wdata,
    output logic [NV*NH*WW-1:0]  w_flat,
    output logic [NV*WW-1:0]     vb_flat,
    output logic [NH*WW-1:0]     hb_flat
);
    localparam int NW_REG = NV * NH;
    localparam int NREG   = NW_REG + NV + NH;

    logic [WW-1:0] regs [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Capture one register on a matching unlocked write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[k] <= '0;
            end else if (we && !lock && addr == ADDR_W'(k)) begin
                regs[k] <= wdata;
            end
        end
    end

    for (genvar k = 0; k < NW_REG; k++) begin : g_wout
        assign w_flat[k*WW +: WW] = regs[k];
    end
    for (genvar k = 0; k < NV; k++) begin : g_vbout
        assign vb_flat[k*WW +: WW] = regs[NW_REG + k];
    end
    for (genvar k = 0; k < NH; k++) begin : g_hbout
        assign hb_flat[k*WW +: WW] = regs[NW_REG + NV + k];
    end
endmodule

// File: rtl/rbm_layer_sampler.sv
`timescale 1ns/1ps
// Combinational stochastic threshold sampler for one layer.
// Output o fires when bias_o + sum(active input weights) - leak >= noise_o,
// all signed. Weight for (o,i) sits at slice o*NIN+i. Assumes the caller
// registers 'fire' only on its update cycle.
module rbm_layer_sampler #(
    parameter int NIN  = 3,
    parameter int NOUT = 2,
    parameter int WW   = 8,
    parameter int NW   = 8
) (
    input  logic [NIN-1:0]          x,
    input  logic [NOUT*NIN*WW-1:0]  wts,
    input  logic [NOUT*WW-1:0]      bias,
    input  logic [NW-1:0]           leak,
    input  logic [NOUT*NW-1:0]      noise,
    output logic [NOUT-1:0]         fire
);
    localparam int BASE_W = (WW > NW) ? WW : NW;
    localparam int ACC_W  = BASE_W + $clog2(NIN + 2) + 1;
    localparam int XW     = ACC_W - WW;
    localparam int XN     = ACC_W - NW;

    logic signed [ACC_W-1:0] leak_s;
    assign leak_s = {{XN{leak[NW-1]}}, leak};

    for (genvar o = 0; o < NOUT; o++) begin : g_unit
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] noise_s;

        assign noise_s = {{XN{noise[o*NW+NW-1]}}, noise[o*NW +: NW]};

        // Sum bias and active weights, then remove the shared leak.
        always_comb begin
            acc = {{XW{bias[o*WW+WW-1]}}, bias[o*WW +: WW]};
            for (int i = 0; i < NIN; i++) begin
                if (x[i]) begin
                    acc = acc + {{XW{wts[(o*NIN+i)*WW+WW-1]}}, wts[(o*NIN+i)*WW +: WW]};
                end
            end
            acc = acc - leak_s;
        end

        assign fire[o] = (acc >= noise_s);
    end
endmodule

// File: rtl/rbm_seq_ctrl.sv
`timescale 1ns/1ps
// Pass sequencer: each layer pass is one update cycle and two sync cycles.
// Inference runs a single hidden pass; generative mode runs hidden+visible
// passes per sweep for the captured number of sweeps (0 counts as 1).
// Assumes 'start' is only honoured in the idle state.
module rbm_seq_ctrl #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             gen_mode,
    input  logic [CNT_W-1:0] iter_count,
    output logic             busy,
    output logic             sweep_valid,
    output logic             load_en,
    output logic             upd_hid,
    output logic             upd_vis
);
    import rbm_gibbs_pkg::*;

    seq_state_t       state;
    layer_sel_t       layer;
    logic             mode_q;
    logic [CNT_W-1:0] remaining;

    assign load_en = (state == SEQ_IDLE) && start;
    assign upd_hid = (state == SEQ_UPDATE) && (layer == LAYER_HID);
    assign upd_vis = (state == SEQ_UPDATE) && (layer == LAYER_VIS);

    // Advance the pass state, sweep counter and result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            layer       <= LAYER_HID;
            mode_q      <= 1'b0;
            remaining   <= '0;
            busy        <= 1'b0;
            sweep_valid <= 1'b0;
        end else begin
            sweep_valid <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state     <= SEQ_UPDATE;
                        layer     <= LAYER_HID;
                        mode_q    <= gen_mode;
                        remaining <= (iter_count == '0) ? CNT_W'(1) : iter_count;
                        busy      <= 1'b1;
                    end
                end
                SEQ_UPDATE: state <= SEQ_SYNC_A;
                SEQ_SYNC_A: state <= SEQ_SYNC_B;
                SEQ_SYNC_B: begin
                    if (layer == LAYER_HID && !mode_q) begin
                        sweep_valid <= 1'b1;
                        busy        <= 1'b0;
                        state       <= SEQ_IDLE;
                    end else if (layer == LAYER_HID) begin
                        layer <= LAYER_VIS;
                        state <= SEQ_UPDATE;
                    end else begin
                        sweep_valid <= 1'b1;
                        if (remaining == CNT_W'(1)) begin
                            busy  <= 1'b0;
                            state <= SEQ_IDLE;
                        end else begin
                            remaining <= remaining - CNT_W'(1);
                            layer     <= LAYER_HID;
                            state     <= SEQ_UPDATE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rbm_gibbs_sequencer.sv
`timescale 1ns/1ps
// Top of the RBM Gibbs sampler: register file, pass sequencer, one
// sampler per layer and the two layer state registers.
// Assumes noise and leak are held stable across each update cycle.
module rbm_gibbs_sequencer #(
    parameter int NV     = 3,
    parameter int NH     = 2,
    parameter int WW     = 8,
    parameter int NW     = 8,
    parameter int CNT_W  = 17,
    parameter int ADDR_W = $clog2(NV*NH + NV + NH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [WW-1:0]         cfg_wdata,
    input  logic                  start,
    input  logic                  gen_mode,
    input  logic [CNT_W-1:0]      iter_count,
    input  logic [NV-1:0]         vis_init,
    input  logic [NW-1:0]         leak,
    input  logic [(NV+NH)*NW-1:0] thr_noise,
    output logic                  busy,
    output logic                  sweep_valid,
    output logic [NV+NH-1:0]      joint_state,
    output logic [NV-1:0]         vis_state,
    output logic [NH-1:0]         hid_state
);
    logic [NV*NH*WW-1:0] w_flat;
    logic [NH*NV*WW-1:0] w_to_hid;
    logic [NV*WW-1:0]    vb_flat;
    logic [NH*WW-1:0]    hb_flat;
    logic [NV-1:0]       vis_fire;
    logic [NH-1:0]       hid_fire;
    logic                load_en;
    logic                upd_hid;
    logic                upd_vis;
    logic [NV-1:0]       vis_q;
    logic [NH-1:0]       hid_q;

    rbm_param_regs #(.NV(NV), .NH(NH), .WW(WW), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .w_flat  (w_flat),
        .vb_flat (vb_flat),
        .hb_flat (hb_flat)
    );

    rbm_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .gen_mode    (gen_mode),
        .iter_count  (iter_count),
        .busy        (busy),
        .sweep_valid (sweep_valid),
        .load_en     (load_en),
        .upd_hid     (upd_hid),
        .upd_vis     (upd_vis)
    );

    // Regroup weights so each hidden unit sees its visible fan-in contiguously.
    for (genvar j = 0; j < NH; j++) begin : g_tr_h
        for (genvar i = 0; i < NV; i++) begin : g_tr_v
            assign w_to_hid[(j*NV+i)*WW +: WW] = w_flat[(i*NH+j)*WW +: WW];
        end
    end

    rbm_layer_sampler #(.NIN(NV), .NOUT(NH), .WW(WW), .NW(NW)) u_hid_sampler (
        .x     (vis_q),
        .wts   (w_to_hid),
        .bias  (hb_flat),
        .leak  (leak),
        .noise (thr_noise[(NV+NH)*NW-1 : NV*NW]),
        .fire  (hid_fire)
    );

    rbm_layer_sampler #(.NIN(NH), .NOUT(NV), .WW(WW), .NW(NW)) u_vis_sampler (
        .x     (hid_q),
        .wts   (w_flat),
        .bias  (vb_flat),
        .leak  (leak),
        .noise (thr_noise[NV*NW-1 : 0]),
        .fire  (vis_fire)
    );

    // Load layers on start, otherwise latch the layer selected for update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
            hid_q <= '0;
        end else if (load_en) begin
            vis_q <= vis_init;
            hid_q <= '0;
        end else begin
            if (upd_hid) hid_q <= hid_fire;
            if (upd_vis) vis_q <= vis_fire;
        end
    end

    assign vis_state   = vis_q;
    assign hid_state   = hid_q;
    assign joint_state = {vis_q, hid_q};
endmodule

// File: rtl/rbm_gibbs_checks.sv
`timescale 1ns/1ps
// Property checker for the Gibbs sampler, bound to the top module.
// Assumes synchronous active-low reset held for at least one edge.
module rbm_gibbs_checks #(
    parameter int NV = 3,
    parameter int NH = 2,
    parameter int WW = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic [NV-1:0]                 vis_init,
    input logic                          busy,
    input logic                          sweep_valid,
    input logic [NV-1:0]                 vis_state,
    input logic [NH-1:0]                 hid_state,
    input logic [(NV*NH+NV+NH)*WW-1:0]   cfg_image
);
    // The result strobe never lasts two clocks.
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_valid |=> !sweep_valid);

    // A result follows a busy clock.
    assert_valid_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_valid |-> $past(busy));

    // Configuration is frozen across a run.
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_image));

    // Hidden layer starts cleared.
    assert_hid_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (hid_state == '0));

    // Accepted start loads the visible layer.
    assert_vis_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (vis_state == $past(vis_init)));

    // Idle with no start leaves both layers unchanged.
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({vis_state, hid_state}));
endmodule

bind rbm_gibbs_sequencer rbm_gibbs_checks #(.NV(NV), .NH(NH), .WW(WW)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .vis_init    (vis_init),
    .busy        (busy),
    .sweep_valid (sweep_valid),
    .vis_state   (vis_state),
    .hid_state   (hid_state),
    .cfg_image   ({w_flat, vb_flat, hb_flat})
);

// File: tb/rbm_gibbs_sequencer_test.sv
`timescale 1ns/1ps
// Self-checking bench: exhaustive inference sweeps plus generative chains,
// with a bench-side arithmetic model of the firing rule.
module rbm_gibbs_sequencer_test;
    localparam int NV = 3, NH = 2, WW = 8, NW = 8, CNT_W = 17, ADDR_W = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst_n;
    logic                  cfg_we;
    logic [ADDR_W-1:0]     cfg_addr;
    logic [WW-1:0]         cfg_wdata;
    logic                  start;
    logic                  gen_mode;
    logic [CNT_W-1:0]      iter_count;
    logic [NV-1:0]         vis_init;
    logic [NW-1:0]         leak;
    logic [(NV+NH)*NW-1:0] thr_noise;
    logic                  busy;
    logic                  sweep_valid;
    logic [NV+NH-1:0]      joint_state;
    logic [NV-1:0]         vis_state;
    logic [NH-1:0]         hid_state;

    rbm_gibbs_sequencer uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .gen_mode(gen_mode),
        .iter_count(iter_count), .vis_init(vis_init), .leak(leak),
        .thr_noise(thr_noise), .busy(busy), .sweep_valid(sweep_valid),
        .joint_state(joint_state), .vis_state(vis_state), .hid_state(hid_state)
    );

    int total = 0;
    int bad   = 0;
    int w [NV][NH];
    int vb [NV];
    int hb [NH];
    int nz [NV+NH];
    int lk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_noise();
        for (int k = 0; k < NV+NH; k++) thr_noise[k*NW +: NW] = 8'(nz[k]);
        leak = 8'(lk);
    endtask

    function automatic logic [NH-1:0] hid_fn(input logic [NV-1:0] v);
        logic [NH-1:0] r;
        for (int j = 0; j < NH; j++) begin
            int acc = hb[j] - lk;
            for (int i = 0; i < NV; i++) if (v[i]) acc += w[i][j];
            r[j] = (acc >= nz[NV+j]);
        end
        return r;
    endfunction

    function automatic logic [NV-1:0] vis_fn(input logic [NH-1:0] h);
        logic [NV-1:0] r;
        for (int i = 0; i < NV; i++) begin
            int acc = vb[i] - lk;
            for (int j = 0; j < NH; j++) if (h[j]) acc += w[i][j];
            r[i] = (acc >= nz[i]);
        end
        return r;
    endfunction

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input int a, input int d, input bit accept);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (accept) begin
            if (a < 6) w[a/2][a%2] = d;
            else if (a < 9) vb[a-6] = d;
            else if (a < 11) hb[a-9] = d;
        end
    endtask

    task automatic load_random();
        for (int a = 0; a < 11; a++) wr(a, int'($urandom_range(40)) - 20, 1'b1);
    endtask

    task automatic rand_noise();
        for (int k = 0; k < NV+NH; k++) nz[k] = int'($urandom_range(80)) - 40;
        lk = int'($urandom_range(20)) - 10;
        drive_noise();
    endtask

    task automatic run_inf(input logic [NV-1:0] v, input string tag);
        logic [NV+NH-1:0] exp_j;
        vis_init = v; gen_mode = 1'b0; iter_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && vis_state == v && hid_state == '0, "R4 load on start",
            int'({busy, vis_state, hid_state}), int'({1'b1, v, 2'b00}));
        @(negedge clk);
        @(negedge clk);
        chk(sweep_valid == 1'b0, "R7 no early result", int'(sweep_valid), 0);
        @(negedge clk);
        exp_j = {v, hid_fn(v)};
        chk(sweep_valid == 1'b1, "R7 result on third edge", int'(sweep_valid), 1);
        chk(joint_state == exp_j, tag, int'(joint_state), int'(exp_j));
        chk(busy == 1'b0, "R7 busy falls with result", int'(busy), 0);
    endtask

    task automatic run_gen(input logic [NV-1:0] v, input int n,
                           input bit poke_start, input bit poke_write);
        int neff = (n == 0) ? 1 : n;
        int c = 0;
        int k = 0;
        logic [NV-1:0] ev = v;
        logic [NH-1:0] eh = '0;
        vis_init = v; gen_mode = 1'b1; iter_count = 17'(n); start = 1'b1;
        while (c < 6*neff + 1) begin
            @(negedge clk);
            c++;
            if (c == 1) start = 1'b0;
            if (poke_start && c == 3) begin start = 1'b1; vis_init = ~v; end
            if (poke_start && c == 4) start = 1'b0;
            if (poke_write && c == 2) begin cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 8'd127; end
            if (poke_write && c == 3) cfg_we = 1'b0;
            if (c == 6*(k+1) + 1) begin
                eh = hid_fn(ev);
                ev = vis_fn(eh);
                chk(sweep_valid == 1'b1, "R8 result at sweep end", int'(sweep_valid), 1);
                chk(joint_state == {ev, eh}, "R6 R8 joint state after sweep",
                    int'(joint_state), int'({ev, eh}));
                k++;
                rand_noise();
            end else begin
                chk(sweep_valid == 1'b0, "R10 no stray result", int'(sweep_valid), 0);
            end
            if (c < 6*neff + 1) chk(busy == 1'b1, "R9 busy held during chain", int'(busy), 1);
        end
        chk(busy == 1'b0, "R9 busy falls with last sweep", int'(busy), 0);
        chk(k == neff, "R9 sweep count", k, neff);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(7));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; start = 1'b0;
        gen_mode = 1'b0; iter_count = '0; vis_init = '0;
        for (int k = 0; k < NV+NH; k++) nz[k] = 0;
        lk = 0;
        for (int i = 0; i < NV; i++) begin
            vb[i] = 0;
            for (int j = 0; j < NH; j++) w[i][j] = 0;
        end
        for (int j = 0; j < NH; j++) hb[j] = 0;
        drive_noise();
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && sweep_valid == 1'b0 && joint_state == '0, "R1 state in reset",
            int'({busy, sweep_valid, joint_state}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && sweep_valid == 1'b0 && joint_state == '0, "R1 state after reset",
            int'({busy, sweep_valid, joint_state}), 0);

        // R5 R6 R2: exhaustive inference over visible patterns, weights and noise
        for (int ws = 0; ws < 4; ws++) begin
            load_random();
            for (int ns = 0; ns < 4; ns++) begin
                rand_noise();
                for (int v = 0; v < 8; v++) run_inf(3'(v), "R5 R2 inference hidden sample");
            end
        end

        // R11: leak shared by all units, equality boundary
        wr(9, 10, 1'b1);
        for (int k = 0; k < NV+NH; k++) nz[k] = 0;
        lk = 10; drive_noise();
        run_inf(3'b000, "R11 leak equal to bias fires");
        chk(hid_fn(3'b000) == 2'b01 || hb[1] >= 10, "R11 model sanity", int'(hid_fn(3'b000)), 1);
        lk = 11; drive_noise();
        run_inf(3'b000, "R11 leak above bias silences");

        // R2: out-of-range address leaves every register alone
        wr(15, 127, 1'b0);
        wr(11, 127, 1'b0);
        for (int k = 0; k < NV+NH; k++) nz[k] = 100;
        lk = 0; drive_noise();
        for (int v = 0; v < 8; v++) run_inf(3'(v), "R2 unmapped write ignored");

        // R8 R9: generative chains, including count 0 and a long chain
        load_random();
        rand_noise();
        run_gen(3'b101, 1, 1'b0, 1'b0);
        rand_noise();
        run_gen(3'b010, 0, 1'b0, 1'b0);
        rand_noise();
        run_gen(3'b111, 1500, 1'b0, 1'b0);

        // R4: start during a run is ignored
        rand_noise();
        run_gen(3'b001, 5, 1'b1, 1'b0);

        // R3: write during a run is discarded
        rand_noise();
        run_gen(3'b110, 3, 1'b0, 1'b1);
        for (int k = 0; k < NV+NH; k++) nz[k] = 100;
        lk = 0; drive_noise();
        run_inf(3'b000, "R3 busy write discarded");

        // R6: idle without start holds the layers
        begin
            logic [NV+NH-1:0] held;
            held = joint_state;
            vis_init = ~vis_state;
            repeat (5) @(negedge clk);
            chk(joint_state == held && sweep_valid == 1'b0, "R6 idle hold",
                int'(joint_state), int'(held));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule